// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns characters into asynchronous serial frames on a single output line. Each frame is a low start bit, then 6, 7 or 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Three coded fields choose the frame shape. The shape is captured with each character, so a field that changes while a frame is on the line does not affect that frame. A one-cycle baud tick from an outside divider ends each bit period.

Characters enter on a valid/ready stream port. A transfer happens on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` depends only on internal state and never on `in_valid`. It stays low while a frame or a break is in progress, so a source holding `in_valid` simply waits. Two separate command bits start and end a break, which drives the line low. A break waits for any frame already on the line to finish before it takes the line.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, `tx_line` is high, `in_ready` is high and `tx_active` is low.
- R2: A character is taken on an edge where `in_valid` and `in_ready` are both high. From the next cycle until its frame ends, `tx_active` is high and `in_ready` is low. Whenever `in_ready` is high, the line is high.
- R3: The start bit (low) begins the cycle after the character is taken. Data bits follow, least significant first. Each bit, parity bit and stop bit holds until a `baud_tick` is seen, and it changes in the cycle after that tick. A tick seen while the block is idle has no effect.
- R4: `mode_len` code 0 or 1 sends 8 data bits, code 2 sends 7 and code 3 sends 6. Character bits above the selected length are neither sent nor counted in parity.
- R5: `mode_par` code 0 adds an even parity bit and code 1 an odd one. Code 2 adds a bit that is always 0 and code 3 a bit that is always 1. Codes 4 to 7 add no parity bit.
- R6: `mode_stop` code 2 sends two high stop bits; codes 0, 1 and 3 send one.
- R7: The three mode fields are sampled only when a character is taken. Changing them while its frame is on the line has no effect on that frame.
- R8: A one-cycle `brk_start` latches a break request. Once no frame is in progress, the line goes low and `in_ready` stays low for as long as the request stands. A character partly sent when the request arrives completes first.
- R9: `brk_stop` clears the request. One cycle later the line is high again, and `in_ready` is high if no new request has arrived. If `brk_start` and `brk_stop` are both high in the same cycle, the stop wins.
- R10: `tx_active` is low during a break. `in_valid` presented during a break is not taken, and no frame is sent for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse that ends the current bit period |
| mode_len | input | 2 | Character length code |
| mode_par | input | 3 | Parity kind code |
| mode_stop | input | 2 | Stop-bit count code |
| brk_start | input | 1 | Command: request a break |
| brk_stop | input | 1 | Command: clear the break request |
| in_data | input | 8 | Character to send |
| in_valid | input | 1 | Character on `in_data` is offered |
| in_ready | output | 1 | Block can take a character this cycle |
| tx_line | output | 1 | Serial output, high when idle |
| tx_active | output | 1 | A frame is being shifted out |

## Verification
The bench sends characters in every length and parity mode and with both stop counts, including characters whose upper bits are set beyond the selected length. A design that failed to mask those bits would show a wrong parity bit. The bench also changes the mode fields in the middle of a frame, which would bend the frame if the fields were read live instead of captured. A break requested halfway through a character must leave the rest of the character intact, where an eager design would cut it short. Characters offered back-to-back and characters offered during a break check that none is dropped, sent twice, or accepted while the line is held low. Simultaneous start and stop commands check that a stray break never starts.

// File: rtl/sftx_pkg.sv
package sftx_pkg;
  parameter int unsigned CHAR_BITS = 8;
  parameter int unsigned STOP_MAX  = 2;
  localparam int unsigned NB_W     = $clog2(CHAR_BITS + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BREAK
  } tx_state_e;

  typedef enum logic [1:0] {
    PK_EVEN, PK_ODD, PK_ZERO, PK_ONE
  } par_kind_e;

  typedef struct packed {
    logic [NB_W-1:0] nbits;
    logic            par_en;
    par_kind_e       par_kind;
    logic            two_stop;
  } frame_cfg_t;
endpackage

// File: rtl/sftx_mode_dec.sv
module sftx_mode_dec
  import sftx_pkg::*;
(
  input  logic [1:0]  len_code,
  input  logic [2:0]  par_code,
  input  logic [1:0]  stop_code,
  output frame_cfg_t  cfg
);
  always_comb begin
    unique case (len_code)
      2'd2:    cfg.nbits = NB_W'(CHAR_BITS - 1);
      2'd3:    cfg.nbits = NB_W'(CHAR_BITS - 2);
      default: cfg.nbits = NB_W'(CHAR_BITS);
    endcase
    cfg.par_en = (par_code < 3'd4);
    unique case (par_code[1:0])
      2'd0:    cfg.par_kind = PK_EVEN;
      2'd1:    cfg.par_kind = PK_ODD;
      2'd2:    cfg.par_kind = PK_ZERO;
      default: cfg.par_kind = PK_ONE;
    endcase
    cfg.two_stop = (stop_code == 2'd2);
  end
endmodule

// File: rtl/sftx_parity.sv
module sftx_parity
  import sftx_pkg::*;
#(
  parameter int unsigned DATA_W = CHAR_BITS
) (
  input  logic [DATA_W-1:0] data,
  input  logic [NB_W-1:0]   nbits,
  input  par_kind_e         kind,
  output logic              par_bit
);
  logic [DATA_W-1:0] kept;

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign kept[g] = data[g] & (NB_W'(g) < nbits);
  end

  always_comb begin
    unique case (kind)
      PK_EVEN: par_bit = ^kept;
      PK_ODD:  par_bit = ~^kept;
      PK_ZERO: par_bit = 1'b0;
      default: par_bit = 1'b1;
    endcase
  end
endmodule

// File: rtl/sftx_brk_ctl.sv
module sftx_brk_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_start,
  input  logic cmd_stop,
  output logic brk_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         brk_req <= 1'b0;
    else if (cmd_stop)  brk_req <= 1'b0;
    else if (cmd_start) brk_req <= 1'b1;
  end

  p_stop_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |=> !brk_req);
  p_start_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && !cmd_stop) |=> brk_req);
endmodule

// File: rtl/sftx_shifter.sv
module sftx_shifter
  import sftx_pkg::*;
#(
  parameter int unsigned DATA_W = CHAR_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic [NB_W-1:0]   load_nbits,
  input  logic              load_par_en,
  input  logic              load_par_bit,
  input  logic              load_two_stop,
  input  logic              brk_req,
  output logic              line,
  output logic              active,
  output logic              idle
);
  tx_state_e         st;
  logic [DATA_W-1:0] sh;
  logic [NB_W-1:0]   bitcnt;
  logic [NB_W-1:0]   nbits_q;
  logic              par_en_q, par_q, two_stop_q, stop2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      sh         <= '0;
      bitcnt     <= '0;
      nbits_q    <= NB_W'(DATA_W);
      par_en_q   <= 1'b0;
      par_q      <= 1'b0;
      two_stop_q <= 1'b0;
      stop2_q    <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (brk_req) begin
            st <= ST_BREAK;
          end else if (load) begin
            st         <= ST_START;
            sh         <= load_data;
            nbits_q    <= load_nbits;
            par_en_q   <= load_par_en;
            par_q      <= load_par_bit;
            two_stop_q <= load_two_stop;
            bitcnt     <= '0;
            stop2_q    <= 1'b0;
          end
        end
        ST_START: if (tick) st <= ST_DATA;
        ST_DATA: begin
          if (tick) begin
            if (bitcnt == nbits_q - NB_W'(1)) begin
              st <= par_en_q ? ST_PAR : ST_STOP;
            end else begin
              sh     <= sh >> 1;
              bitcnt <= bitcnt + NB_W'(1);
            end
          end
        end
        ST_PAR: if (tick) st <= ST_STOP;
        ST_STOP: begin
          if (tick) begin
            if (two_stop_q && !stop2_q) stop2_q <= 1'b1;
            else                        st      <= ST_IDLE;
          end
        end
        ST_BREAK: if (!brk_req) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (st)
      ST_START, ST_BREAK: line = 1'b0;
      ST_DATA:            line = sh[0];
      ST_PAR:             line = par_q;
      default:            line = 1'b1;
    endcase
  end

  assign active = (st != ST_IDLE) && (st != ST_BREAK);
  assign idle   = (st == ST_IDLE);

  // break may only be entered from an idle line (R8)
  p_brk_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BREAK) |-> ($past(st) == ST_IDLE || $past(st) == ST_BREAK));
  // a bit holds until the baud tick (R3)
  p_hold_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick) |=> ($stable(line) && active));
  // a frame in progress ignores break requests until the stop bit ends (R8)
  p_frame_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick) |=> (st != ST_BREAK));
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sftx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 baud_tick,
  input  logic [1:0]           mode_len,
  input  logic [2:0]           mode_par,
  input  logic [1:0]           mode_stop,
  input  logic                 brk_start,
  input  logic                 brk_stop,
  input  logic [CHAR_BITS-1:0] in_data,
  input  logic                 in_valid,
  output logic                 in_ready,
  output logic                 tx_line,
  output logic                 tx_active
);
  frame_cfg_t cfg;
  logic       par_bit, brk_req, sh_idle, take;

  sftx_mode_dec u_dec (
    .len_code (mode_len),
    .par_code (mode_par),
    .stop_code(mode_stop),
    .cfg      (cfg)
  );

  sftx_parity #(.DATA_W(CHAR_BITS)) u_par (
    .data   (in_data),
    .nbits  (cfg.nbits),
    .kind   (cfg.par_kind),
    .par_bit(par_bit)
  );

  sftx_brk_ctl u_brk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_start(brk_start),
    .cmd_stop (brk_stop),
    .brk_req  (brk_req)
  );

  assign in_ready = sh_idle && !brk_req;
  assign take     = in_valid && in_ready;

  sftx_shifter #(.DATA_W(CHAR_BITS)) u_sh (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (baud_tick),
    .load         (take),
    .load_data    (in_data),
    .load_nbits   (cfg.nbits),
    .load_par_en  (cfg.par_en),
    .load_par_bit (par_bit),
    .load_two_stop(cfg.two_stop),
    .brk_req      (brk_req),
    .line         (tx_line),
    .active       (tx_active),
    .idle         (sh_idle)
  );

  p_ready_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (tx_line && !tx_active));
  p_accept_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (tx_active && !tx_line && !in_ready));
  p_break_inactive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_line && !tx_active) |-> !in_ready);
endmodule

// File: tb/sim_serial_frame_tx.sv
module sim_serial_frame_tx;
  localparam int TICK_DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic [1:0] mode_len = 2'd0;
  logic [2:0] mode_par = 3'd4;
  logic [1:0] mode_stop = 2'd0;
  logic       brk_start = 1'b0, brk_stop = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_ready, tx_line, tx_active;

  always #4 clk = ~clk;

  serial_frame_tx u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .mode_len(mode_len), .mode_par(mode_par), .mode_stop(mode_stop),
    .brk_start(brk_start), .brk_stop(brk_stop),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .tx_line(tx_line), .tx_active(tx_active)
  );

  int    n_chk = 0, n_fail = 0, cycles = 0, tdiv = 0;
  string cur_req = "R1";

  // behavioural reference: a queue of line levels for the frame on the wire
  bit q[$];
  bit m_brk = 0, m_req = 0;

  task automatic push_frame();
    int nb;
    bit p;
    nb = (mode_len == 2'd2) ? 7 : (mode_len == 2'd3) ? 6 : 8;
    p = 0;
    q.push_back(1'b0);
    for (int i = 0; i < nb; i++) begin
      q.push_back(in_data[i]);
      p = p ^ in_data[i];
    end
    case (mode_par)
      3'd0: q.push_back(p);
      3'd1: q.push_back(~p);
      3'd2: q.push_back(1'b0);
      3'd3: q.push_back(1'b1);
      default: ;
    endcase
    q.push_back(1'b1);
    if (mode_stop == 2'd2) q.push_back(1'b1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      q.delete();
      m_brk = 0;
      m_req = 0;
    end else begin
      bit was_empty;
      was_empty = (q.size() == 0);
      if (!was_empty && baud_tick) void'(q.pop_front());
      if (was_empty) begin
        if (m_brk) begin
          if (!m_req) m_brk = 0;
        end else if (m_req) begin
          m_brk = 1;
        end else if (in_valid) begin
          push_frame();
        end
      end
      if (brk_stop) m_req = 0;
      else if (brk_start) m_req = 1;
    end
  end

  task automatic check(input string what, input bit act, input bit exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("tx_line", tx_line, (q.size() != 0) ? q[0] : !m_brk);
      check("tx_active", tx_active, q.size() != 0);
      check("in_ready", in_ready, (q.size() == 0) && !m_brk && !m_req);
    end
  end

  always @(negedge clk) begin
    if (!rst_n) tdiv <= 0;
    else tdiv <= (tdiv + 1) % TICK_DIV;
    baud_tick <= rst_n && (tdiv == TICK_DIV - 1);
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL %s watchdog actual=hung expected=finished", cur_req);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic send(input [7:0] d, input [1:0] l, input [2:0] p, input [1:0] s, input string r);
    cur_req = r;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_data = d; mode_len = l; mode_par = p; mode_stop = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (tx_active || !in_ready) @(negedge clk);
  endtask

  task automatic pulse_cmd(input bit st, input bit sp);
    @(negedge clk);
    brk_start = st; brk_stop = sp;
    @(negedge clk);
    brk_start = 1'b0; brk_stop = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check("reset tx_line", tx_line, 1'b1);
    check("reset in_ready", in_ready, 1'b1);
    check("reset tx_active", tx_active, 1'b0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    send(8'hA5, 2'd0, 3'd4, 2'd0, "R3");  wait_idle();
    send(8'h3C, 2'd1, 3'd0, 2'd0, "R4");  wait_idle();
    send(8'hC0, 2'd3, 3'd0, 2'd0, "R4");  wait_idle();
    send(8'hFF, 2'd2, 3'd1, 2'd2, "R6");  wait_idle();
    send(8'h5A, 2'd0, 3'd0, 2'd3, "R5");  wait_idle();
    send(8'h01, 2'd0, 3'd1, 2'd1, "R5");  wait_idle();
    send(8'hFF, 2'd0, 3'd2, 2'd0, "R5");  wait_idle();
    send(8'h00, 2'd3, 3'd3, 2'd2, "R5");  wait_idle();
    send(8'h96, 2'd2, 3'd6, 2'd0, "R5");  wait_idle();

    // R2: back-to-back characters with valid held
    cur_req = "R2";
    @(negedge clk);
    in_data = 8'h81; mode_len = 2'd0; mode_par = 3'd0; mode_stop = 2'd0; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_data = 8'h7E;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    wait_idle();

    // R7: mode changed while frame is on the line
    send(8'hB7, 2'd0, 3'd4, 2'd0, "R7");
    repeat (10) @(negedge clk);
    mode_len = 2'd3; mode_par = 3'd3; mode_stop = 2'd2;
    wait_idle();

    // R8: break requested mid-frame waits for the frame
    send(8'h69, 2'd0, 3'd1, 2'd2, "R8");
    repeat (6) @(negedge clk);
    pulse_cmd(1'b1, 1'b0);
    repeat (120) @(negedge clk);
    // R10: characters offered during break are ignored
    cur_req = "R10";
    in_data = 8'h55; in_valid = 1'b1;
    repeat (20) @(negedge clk);
    in_valid = 1'b0;
    cur_req = "R9";
    pulse_cmd(1'b0, 1'b1);
    wait_idle();

    // R9: simultaneous commands, stop wins
    pulse_cmd(1'b1, 1'b1);
    repeat (10) @(negedge clk);
    // R8: break from an idle line, then R9 release
    cur_req = "R8";
    pulse_cmd(1'b1, 1'b0);
    repeat (15) @(negedge clk);
    cur_req = "R9";
    pulse_cmd(1'b0, 1'b1);
    repeat (3) @(negedge clk);
    check("released line", tx_line, 1'b1);
    send(8'h3A, 2'd2, 3'd0, 2'd2, "R3");
    wait_idle();
    repeat (5) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule